// File: doc/BRIEF.md
# Grouped Event Packet Encoder

This block turns a frame of 2-bit per-pixel event codes into a sparse stream of 32-bit typed words. The frame arrives column by column, one group of neighbouring pixels per input beat, with markers for the last group of a column and the last column of a frame. Groups whose pixels carry no event are dropped. A column that holds at least one event is announced by a column word placed just before its first non-empty group. Every frame closes with a frame-end word that carries a packet count, which lets a receiver detect lost words.

The word type sits in the upper six bits of each word. A downstream serializer drains the output through a valid/ready handshake. When the output stalls, input acceptance stops, and no word is dropped or reordered.

Top module: `evp_group_encoder`

## Requirements
- R1: Bits [31:26] of every output word hold its type: 6'h01 for a column word, 6'h02 for a group word, 6'h3F for a frame-end word.
- R2: A column word holds the column index in bits [25:14], the frame number in bits [13:6], and in bits [5:0] the `in_info` value of the beat that opened the column. The column index counts accepted columns from 0 within the frame.
- R3: A group word holds the group index within its column in bits [25:16] and the beat's 16 code bits in bits [15:0], with pixel k in bits [2k+1:2k]. Group indices count accepted beats from 0 within the column.
- R4: A beat whose codes are all 00 emits no group word. A column whose beats are all 00 emits no column word.
- R5: Each column emits at most one column word, placed directly before the group word of its first non-empty beat.
- R6: The beat with both `in_last_grp` and `in_last_col` set is followed by one frame-end word, even when the frame had no events. Its bits [25:0] hold the number of column and group words of that frame, modulo 2^26.
- R7: The frame number is 0 after reset, rises by one after each frame-end word, and wraps from 255 to 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. Under any `out_ready` pattern, every word appears exactly once and in order.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: Each of the codes 01, 10 and 11 counts as an event on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Encoder accepts a beat this cycle |
| in_codes | input | 16 | Codes of the 8 pixels of one group |
| in_last_grp | input | 1 | Beat is the last group of its column |
| in_last_col | input | 1 | Beat belongs to the last column of the frame |
| in_info | input | 6 | Frame information placed in the column word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_data | output | 32 | Encoded word |

## Verification
A sparse frame has events in only a few groups, including a column with none. It separates correct skipping and lazy column announcement from a raw per-group dump. An all-empty frame must yield only a frame-end word with count 0. A dense frame uses each single code value 01, 10 and 11 and runs under random output backpressure, which exposes lost, duplicated or reordered words and a weak event detector. A long run of tiny frames carries the frame number across its wrap, so column words in frames 255 and 0 check the counter width.

// File: rtl/evp_pkg.sv
package evp_pkg;
    localparam int WORD_W = 32;
    localparam int TYPE_W = 6;
    localparam int BODY_W = WORD_W - TYPE_W;

    typedef enum logic [TYPE_W-1:0] {
        PKT_COL = 6'h01,
        PKT_GRP = 6'h02,
        PKT_END = 6'h3F
    } pkt_type_e;
endpackage

// File: rtl/evp_group_detect.sv
module evp_group_detect #(
    parameter int GRP_PIX = 8
) (
    input  logic [2*GRP_PIX-1:0] codes,
    output logic                 has_event
);
    logic [GRP_PIX-1:0] pix_hit;

    for (genvar i = 0; i < GRP_PIX; i++) begin : g_pix
        // any non-zero code counts as an event
        assign pix_hit[i] = |codes[2*i+1:2*i];
    end

    assign has_event = |pix_hit;
endmodule

// File: rtl/evp_word_build.sv
module evp_word_build
    import evp_pkg::*;
#(
    parameter int GRP_PIX = 8,
    parameter int COL_AW  = 12,
    parameter int GRP_AW  = 10,
    parameter int FRM_W   = 8,
    parameter int INFO_W  = 6
) (
    input  logic                    has_event,
    input  logic                    col_open,
    input  logic                    frame_last,
    input  logic [COL_AW-1:0]       col_idx,
    input  logic [GRP_AW-1:0]       grp_idx,
    input  logic [FRM_W-1:0]        frm_num,
    input  logic [INFO_W-1:0]       info,
    input  logic [2*GRP_PIX-1:0]    codes,
    input  logic [BODY_W-1:0]       pkt_cnt,
    output logic [2:0][WORD_W-1:0]  words,
    output logic [1:0]              push_n,
    output logic [1:0]              data_n
);
    logic              need_col;
    logic [WORD_W-1:0] col_word;
    logic [WORD_W-1:0] grp_word;
    logic [WORD_W-1:0] end_word;

    assign need_col = has_event && !col_open;
    assign data_n   = 2'(need_col) + 2'(has_event);
    assign col_word = {PKT_COL, col_idx, frm_num, info};
    assign grp_word = {PKT_GRP, grp_idx, codes};
    assign end_word = {PKT_END, pkt_cnt + BODY_W'(data_n)};

    // pack the words of one beat in emission order
    always_comb begin
        words  = '0;
        push_n = 2'd0;
        if (need_col) begin
            words[push_n] = col_word;
            push_n        = push_n + 2'd1;
        end
        if (has_event) begin
            words[push_n] = grp_word;
            push_n        = push_n + 2'd1;
        end
        if (frame_last) begin
            words[push_n] = end_word;
            push_n        = push_n + 2'd1;
        end
    end
endmodule

// File: rtl/evp_word_fifo.sv
module evp_word_fifo #(
    parameter int DEPTH    = 4,
    parameter int W        = 32,
    parameter int PUSH_MAX = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PUSH_MAX-1:0][W-1:0]   words,
    input  logic [$clog2(PUSH_MAX+1)-1:0] push_n,
    output logic                         space_ok,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [W-1:0]                 out_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic  pop;

    assign out_valid = (q.cnt != '0);
    assign out_data  = q.mem[q.rd];
    assign pop       = out_valid && out_ready;
    // registered count only: no path from out_ready to space_ok
    assign space_ok  = (q.cnt <= CNT_W'(DEPTH - PUSH_MAX));

    always_comb begin
        d = q;
        for (int k = 0; k < PUSH_MAX; k++) begin
            if (k < int'(push_n)) begin
                d.mem[q.wr + PTR_W'(k)] = words[k];
            end
        end
        d.wr  = q.wr + PTR_W'(push_n);
        d.rd  = q.rd + PTR_W'(pop);
        d.cnt = q.cnt + CNT_W'(push_n) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/evp_group_encoder.sv
module evp_group_encoder
    import evp_pkg::*;
#(
    parameter int GRP_PIX    = 8,
    parameter int COL_AW     = 12,
    parameter int GRP_AW     = 10,
    parameter int FRM_W      = 8,
    parameter int INFO_W     = 6,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [2*GRP_PIX-1:0]   in_codes,
    input  logic                   in_last_grp,
    input  logic                   in_last_col,
    input  logic [INFO_W-1:0]      in_info,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [WORD_W-1:0]      out_data
);
    localparam int GRP_BITS = 2 * GRP_PIX;
    localparam int PUSH_MAX = 3;

    typedef struct packed {
        logic [COL_AW-1:0] col;
        logic [GRP_AW-1:0] grp;
        logic              col_open;
        logic [FRM_W-1:0]  frm;
        logic [BODY_W-1:0] pkt_cnt;
    } state_t;

    state_t q, d;

    logic                          accept;
    logic                          has_event;
    logic                          frame_last;
    logic [PUSH_MAX-1:0][WORD_W-1:0] words;
    logic [1:0]                    push_n;
    logic [1:0]                    data_n;
    logic [1:0]                    fifo_push_n;
    logic                          space_ok;

    assign accept      = in_valid && in_ready;
    assign in_ready    = space_ok;
    assign frame_last  = in_last_grp && in_last_col;
    assign fifo_push_n = accept ? push_n : 2'd0;

    evp_group_detect #(.GRP_PIX(GRP_PIX)) i_detect (
        .codes     (in_codes),
        .has_event (has_event)
    );

    evp_word_build #(
        .GRP_PIX (GRP_PIX),
        .COL_AW  (COL_AW),
        .GRP_AW  (GRP_AW),
        .FRM_W   (FRM_W),
        .INFO_W  (INFO_W)
    ) i_build (
        .has_event  (has_event),
        .col_open   (q.col_open),
        .frame_last (frame_last),
        .col_idx    (q.col),
        .grp_idx    (q.grp),
        .frm_num    (q.frm),
        .info       (in_info),
        .codes      (in_codes),
        .pkt_cnt    (q.pkt_cnt),
        .words      (words),
        .push_n     (push_n),
        .data_n     (data_n)
    );

    evp_word_fifo #(
        .DEPTH    (FIFO_DEPTH),
        .W        (WORD_W),
        .PUSH_MAX (PUSH_MAX)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .words     (words),
        .push_n    (fifo_push_n),
        .space_ok  (space_ok),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always_comb begin
        d = q;
        if (accept) begin
            if (has_event) d.col_open = 1'b1;
            d.pkt_cnt = q.pkt_cnt + BODY_W'(data_n);
            if (in_last_grp) begin
                d.grp      = '0;
                d.col      = q.col + COL_AW'(1);
                d.col_open = 1'b0;
            end else begin
                d.grp = q.grp + GRP_AW'(1);
            end
            if (frame_last) begin
                d.col     = '0;
                d.frm     = q.frm + FRM_W'(1);
                d.pkt_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1
    legal_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[WORD_W-1 -: TYPE_W] == PKT_COL ||
                       out_data[WORD_W-1 -: TYPE_W] == PKT_GRP ||
                       out_data[WORD_W-1 -: TYPE_W] == PKT_END));

    // R4
    grp_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data[WORD_W-1 -: TYPE_W] == PKT_GRP
        |-> out_data[GRP_BITS-1:0] != '0);
endmodule

// File: tb/test_evp_group_encoder.sv
module test_evp_group_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_codes = '0;
    logic        in_last_grp = 1'b0;
    logic        in_last_col = 1'b0;
    logic [5:0]  in_info = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   bp_on = 1'b0;
    bit   run_col = 1'b0;
    bit   done = 1'b0;
    logic [7:0]  frm_exp = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    evp_group_encoder i_evp_group_encoder (
        .clk, .rst_n, .in_valid, .in_ready, .in_codes, .in_last_grp,
        .in_last_col, .in_info, .out_valid, .out_ready, .out_data
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // collector: ready is chosen first, then the handshake is judged
    initial begin
        forever begin
            @(negedge clk);
            if (run_col) begin
                out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected word", out_data, 32'h0);
                    end else begin
                        check(out_data === exp_q[0], tag_q[0], out_data, exp_q[0]);
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end
                end
            end
        end
    end

    function automatic logic [15:0] pick_codes(int kind, int col, int grp);
        logic [1:0] c;
        case (kind)
            0: begin  // sparse
                if (col == 1 && grp == 2) return 16'h0040;
                if (col == 2 && grp == 0) return 16'h8000;
                if (col == 2 && grp == 3) return 16'h0003;
                return 16'h0;
            end
            2: begin  // dense, single code values (R10)
                c = 2'((col * 4 + grp) % 4);
                return 16'(c) << (2 * ((col + grp) % 8));
            end
            3: return 16'h0001;
            default: return 16'h0;
        endcase
    endfunction

    task automatic send_beat(input logic [15:0] codes, input bit lg, input bit lc,
                             input logic [5:0] info);
        @(negedge clk);
        in_valid = 1'b1; in_codes = codes; in_last_grp = lg;
        in_last_col = lc; in_info = info;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // drives one frame and queues the words the requirements call for
    task automatic run_frame(input int ncol, input int ngrp, input int kind);
        int cnt = 0;
        for (int c = 0; c < ncol; c++) begin
            bit opened = 1'b0;
            for (int g = 0; g < ngrp; g++) begin
                logic [15:0] codes = pick_codes(kind, c, g);
                logic [5:0]  info = 6'(c * 5 + 3 + int'(frm_exp));
                bit lg = (g == ngrp - 1);
                bit lc = (c == ncol - 1);
                if (codes != 0) begin
                    if (!opened) begin
                        // R5: column word right before first non-empty group
                        exp_q.push_back({6'h01, 12'(c), frm_exp, info});
                        tag_q.push_back("R2/R5 column word");
                        cnt++;
                        opened = 1'b1;
                    end
                    exp_q.push_back({6'h02, 10'(g), codes});
                    tag_q.push_back("R3/R10 group word");
                    cnt++;
                end
                if (lg && lc) begin
                    exp_q.push_back({6'h3F, 26'(cnt)});
                    tag_q.push_back("R6 frame-end word");
                end
                send_beat(codes, lg, lc, info);
            end
        end
        frm_exp = frm_exp + 8'd1;   // R7
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (exp_q.size() != 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'h0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 32'h0);
        check(in_ready == 1'b1, "R9 in_ready after reset", 32'(in_ready), 32'h1);
        run_col = 1'b1;
    endtask

    task automatic t_sparse();
        // R1 R4 R5: column 0 empty, column 1 one group, column 2 two groups
        run_frame(3, 4, 0);
        drain("R4 sparse frame drained");
    endtask

    task automatic t_empty();
        run_frame(2, 2, 1);   // R6: only frame-end with count 0
        drain("R6 empty frame drained");
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R4 no stray word after empty frame",
              32'(out_valid), 32'h0);
    endtask

    task automatic t_dense_bp();
        bp_on = 1'b1;          // R8: random backpressure
        run_frame(4, 4, 2);
        run_frame(3, 5, 2);
        drain("R8 dense frames drained under backpressure");
        bp_on = 1'b0;
    endtask

    task automatic t_wrap();
        while (frm_exp != 8'd255) run_frame(1, 1, 1);
        drain("R7 frames up to 255 drained");
        run_frame(1, 1, 3);    // column word frame 255
        run_frame(1, 1, 3);    // column word frame 0 (R7 wrap)
        drain("R7 wrap frames drained");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sparse();
        t_empty();
        t_dense_bp();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule